// File: doc/BRIEF.md
# Coprocessor-0 Hazard Rule Monitor

The monitor watches an in-order stream of retired instructions, one event per clock. Each event carries a valid strobe, an instruction class, the number of the control register it targets, the old and new values of that register, a data or cache address and the fetch address. From this stream it recognises sequences that break the ordering rules of the system-control coprocessor. It does not stall the pipeline and does not change any sequence it flags.

Each flagged event produces a one-cycle violation pulse with a numeric reason code. The block also keeps one sticky status bit per rule, which software clears by writing ones. A separate pulse marks control-register accesses that fall inside the uncertain-mode window opened by a hazardous Status write. Only the ordering rules are tracked: the translation buffer and the caches are not modelled.

Top module: `cp0_hazard_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears all history, `viol_pulse`, `viol_code`, `mode_cp0_hit` and `viol_sticky`.
- R2: Classes on `ev_cls`: 0 other, 1 MTC0, 2 MFC0, 3 load, 4 store, 5 CACHE. An MFC0 whose previous valid event was an MTC0 is flagged with code 1. Cycles with `ev_valid` low neither separate nor advance anything.
- R3: A CACHE event whose address matches the most recent store on bits [31:5] is flagged with code 2 when fewer than two valid events since that store were neither loads nor CACHE. Loads and CACHE events do not count towards the gap. A different line is never flagged.
- R4: An MTC0 to register 12 (Status) that changes KSU (bits 4:3) and takes EXL (bit 1) or ERL (bit 2) from 0 to 1 is flagged with code 3.
- R5: During the five valid events that follow a code-3 write, every MTC0 or MFC0 raises `mode_cp0_hit`. The sixth such event does not.
- R6: Setting EXL with KSU unchanged, then changing KSU in a later write with EXL already 1, raises no flag.
- R7: An MTC0 to Status that takes EXL from 0 to 1 while IE (bit 0) of the old value is 1 is flagged with code 4. Clearing IE in an earlier write avoids the flag.
- R8: An MTC0 to register 16 (Config) that changes K0 (bits 2:0) while the fetch address is in 0x8000_0000..0x9FFF_FFFF opens a window. Any of the next three valid events fetched from that range is flagged with code 5. The same write made from outside that range opens no window.
- R9: When several rules fire on one event, `viol_code` reports the lowest code. `viol_code` is 0 when `viol_pulse` is low.
- R10: Sticky bit k-1 sets when code k's rule fires. A one on `sticky_clr` bit k-1 clears it, and a set in the same cycle wins over the clear.
- R11: All outputs are registered: they reflect the event presented before a rising edge from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event present this cycle |
| ev_cls | input | 3 | Instruction class |
| ev_reg | input | 5 | Control register number |
| ev_old | input | 32 | Register value before the write |
| ev_new | input | 32 | Register value after the write |
| ev_addr | input | 32 | Data or cache address |
| ev_pc | input | 32 | Fetch address |
| sticky_clr | input | 5 | Write-one-to-clear for the sticky bits |
| viol_pulse | output | 1 | One-cycle violation indication |
| viol_code | output | 3 | Reason of the lowest-coded violation |
| mode_cp0_hit | output | 1 | Control-register access inside the mode window |
| viol_sticky | output | 5 | Sticky per-rule status |

## Verification
The hardest situations to reach are the exact edges of the three distance rules: the store-to-CACHE gap, the five-event mode window and the three-event K0 window. Each has to be reached after a precise count of intervening events, and some of those events must not count. The bench resets before every case. It then sweeps the distance from zero or one up to one past the limit and places the probing event at each position. It also mixes in loads and idle cycles, which must leave the counts unchanged.

// File: rtl/cp0_hazard_monitor.sv
module cp0_hazard_monitor #(
  parameter int LINE_LSB = 5,
  parameter int MODE_WIN = 5,
  parameter int K0_WIN   = 3,
  parameter int MIN_GAP  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  input  logic [2:0]  ev_cls,
  input  logic [4:0]  ev_reg,
  input  logic [31:0] ev_old,
  input  logic [31:0] ev_new,
  input  logic [31:0] ev_addr,
  input  logic [31:0] ev_pc,
  input  logic [4:0]  sticky_clr,
  output logic        viol_pulse,
  output logic [2:0]  viol_code,
  output logic        mode_cp0_hit,
  output logic [4:0]  viol_sticky
);
  localparam logic [2:0] C_MTC0 = 3'd1, C_MFC0 = 3'd2, C_LOAD = 3'd3,
                         C_STORE = 3'd4, C_CACHE = 3'd5;
  localparam int MW = $clog2(MODE_WIN + 1);
  localparam int KW = $clog2(K0_WIN + 1);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [MW-1:0] MODE_LD = MW'(MODE_WIN);
  localparam logic [KW-1:0] K0_LD   = KW'(K0_WIN);
  localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);

  logic                  last_mtc0, st_armed;
  logic [31-LINE_LSB:0]  st_line;
  logic [GW-1:0]         st_gap;
  logic [MW-1:0]         mode_cnt;
  logic [KW-1:0]         k0_cnt;
  logic [4:0]            hit;
  logic [2:0]            code;

  wire is_mtc0  = ev_valid && ev_cls == C_MTC0;
  wire is_mfc0  = ev_valid && ev_cls == C_MFC0;
  wire is_store = ev_valid && ev_cls == C_STORE;
  wire is_cache = ev_valid && ev_cls == C_CACHE;
  wire no_gap   = ev_cls == C_LOAD || ev_cls == C_CACHE;
  wire wr_stat  = is_mtc0 && ev_reg == 5'd12;
  wire wr_cfg   = is_mtc0 && ev_reg == 5'd16;
  wire pc_k0    = ev_pc[31:29] == 3'b100;
  wire exl_up   = ev_new[1] & ~ev_old[1];
  wire erl_up   = ev_new[2] & ~ev_old[2];
  wire ksu_chg  = ev_new[4:3] != ev_old[4:3];
  wire k0_chg   = ev_new[2:0] != ev_old[2:0];

  assign hit[0] = is_mfc0 && last_mtc0;
  assign hit[1] = is_cache && st_armed && ev_addr[31:LINE_LSB] == st_line && st_gap < GAP_MAX;
  assign hit[2] = wr_stat && ksu_chg && (exl_up || erl_up);
  assign hit[3] = wr_stat && exl_up && ev_old[0];
  assign hit[4] = ev_valid && k0_cnt != '0 && pc_k0;

  always_comb begin
    code = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (hit[i]) code = 3'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_pulse   <= 1'b0;
      viol_code    <= '0;
      mode_cp0_hit <= 1'b0;
      viol_sticky  <= '0;
      last_mtc0    <= 1'b0;
      st_armed     <= 1'b0;
      st_line      <= '0;
      st_gap       <= '0;
      mode_cnt     <= '0;
      k0_cnt       <= '0;
    end else begin
      viol_pulse   <= |hit;
      viol_code    <= code;
      mode_cp0_hit <= (is_mtc0 || is_mfc0) && mode_cnt != '0;
      viol_sticky  <= (viol_sticky & ~sticky_clr) | hit;
      if (ev_valid) begin
        last_mtc0 <= is_mtc0;
        if (is_store) begin
          st_armed <= 1'b1;
          st_line  <= ev_addr[31:LINE_LSB];
          st_gap   <= '0;
        end else if (!no_gap && st_gap < GAP_MAX) begin
          st_gap <= st_gap + 1'b1;
        end
        if (hit[2])              mode_cnt <= MODE_LD;
        else if (mode_cnt != '0) mode_cnt <= mode_cnt - 1'b1;
        if (wr_cfg && k0_chg && pc_k0) k0_cnt <= K0_LD;
        else if (k0_cnt != '0)         k0_cnt <= k0_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cp0_hazard_monitor_chk.sv
module cp0_hazard_monitor_chk (
  input logic        clk,
  input logic        rst,
  input logic        ev_valid,
  input logic [2:0]  ev_cls,
  input logic [31:0] ev_addr,
  input logic        viol_pulse,
  input logic [2:0]  viol_code,
  input logic [4:0]  viol_sticky
);
  logic seen;
  always_ff @(posedge clk) seen <= rst ? 1'b0 : 1'b1;

  p_mfc_after_mtc_r2: assert property (@(posedge clk) disable iff (rst)
    seen && ev_valid && ev_cls == 3'd2 && $past(ev_valid && ev_cls == 3'd1) |=> viol_pulse);

  p_cache_after_store_r3: assert property (@(posedge clk) disable iff (rst)
    seen && ev_valid && ev_cls == 3'd5 && $past(ev_valid && ev_cls == 3'd4)
    && ev_addr[31:5] == $past(ev_addr[31:5]) |=> viol_pulse);

  p_code_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !viol_pulse |-> viol_code == 3'd0);

  p_code_range_r9: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_code >= 3'd1 && viol_code <= 3'd5);

  p_sticky_follows_r10: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_sticky[viol_code - 3'd1]);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) && seen == 1'b0 |-> !viol_pulse && viol_sticky == '0);
endmodule

bind cp0_hazard_monitor cp0_hazard_monitor_chk u_chk (.*);

// File: tb/test_cp0_hazard_monitor.sv
`timescale 1ns/1ps
module test_cp0_hazard_monitor;
  logic        clk = 0, rst = 1, ev_valid = 0;
  logic [2:0]  ev_cls = 0;
  logic [4:0]  ev_reg = 0, sticky_clr = 0;
  logic [31:0] ev_old = 0, ev_new = 0, ev_addr = 0, ev_pc = 0;
  logic        viol_pulse, mode_cp0_hit;
  logic [2:0]  viol_code;
  logic [4:0]  viol_sticky;
  int checks = 0, errors = 0;

  localparam logic [31:0] PC_U = 32'h0040_0000, PC_K = 32'h8000_0100;

  always #2 clk = ~clk;

  cp0_hazard_monitor i_cp0_hazard_monitor (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [2:0] c, input logic [4:0] r, input logic [31:0] o,
                    input logic [31:0] n, input logic [31:0] a, input logic [31:0] p);
    ev_valid = 1; ev_cls = c; ev_reg = r; ev_old = o; ev_new = n; ev_addr = a; ev_pc = p;
    @(negedge clk);
    ev_valid = 0; sticky_clr = 0;
  endtask

  task automatic idle();
    ev_valid = 0;
    @(negedge clk);
    sticky_clr = 0;
  endtask

  task automatic do_reset();
    rst = 1; ev_valid = 0; sticky_clr = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 pulse", viol_pulse, 0);
    chk("R1 sticky", viol_sticky, 0);
    ev(1, 9, 0, 0, 0, PC_U); ev(2, 9, 0, 0, 0, PC_U);
    do_reset();
    chk("R1 sticky after reset", viol_sticky, 0);
    chk("R1 code after reset", viol_code, 0);

    // R2 and R11
    ev(1, 9, 0, 1, 0, PC_U);
    chk("R11 no pulse on MTC0", viol_pulse, 0);
    ev(2, 9, 0, 0, 0, PC_U);
    chk("R2 back-to-back pulse", viol_pulse, 1);
    chk("R2 code", viol_code, 1);
    chk("R10 sticky bit0", viol_sticky, 5'b00001);
    idle();
    chk("R11 pulse one cycle", viol_pulse, 0);
    do_reset();
    ev(1, 9, 0, 1, 0, PC_U); idle(); idle(); ev(2, 9, 0, 0, 0, PC_U);
    chk("R2 idle does not separate", viol_code, 1);
    do_reset();
    ev(1, 9, 0, 1, 0, PC_U); ev(0, 0, 0, 0, 0, PC_U); ev(2, 9, 0, 0, 0, PC_U);
    chk("R2 separated", viol_pulse, 0);

    // R3 gap sweep
    for (int g = 0; g < 4; g++) begin
      do_reset();
      ev(4, 0, 0, 0, 32'h1040, PC_U);
      for (int k = 0; k < g; k++) ev(0, 0, 0, 0, 0, PC_U);
      ev(5, 0, 0, 0, 32'h105C, PC_U);
      chk($sformatf("R3 gap %0d pulse", g), viol_pulse, g < 2);
      chk($sformatf("R3 gap %0d code", g), viol_code, g < 2 ? 2 : 0);
    end
    do_reset();
    ev(4, 0, 0, 0, 32'h1040, PC_U); ev(3, 0, 0, 0, 0, PC_U); ev(3, 0, 0, 0, 0, PC_U);
    ev(5, 0, 0, 0, 32'h1040, PC_U);
    chk("R3 loads do not count", viol_code, 2);
    do_reset();
    ev(4, 0, 0, 0, 32'h1040, PC_U); ev(0, 0, 0, 0, 0, PC_U); ev(3, 0, 0, 0, 0, PC_U);
    ev(0, 0, 0, 0, 0, PC_U); ev(5, 0, 0, 0, 32'h1040, PC_U);
    chk("R3 two others with load", viol_pulse, 0);
    do_reset();
    ev(4, 0, 0, 0, 32'h1040, PC_U); idle(); idle(); idle();
    ev(5, 0, 0, 0, 32'h1044, PC_U);
    chk("R3 idle cycles do not count", viol_code, 2);
    do_reset();
    ev(4, 0, 0, 0, 32'h1040, PC_U); ev(5, 0, 0, 0, 32'h1060, PC_U);
    chk("R3 other line", viol_pulse, 0);

    // R4 / R5 window sweep
    for (int d = 1; d <= 6; d++) begin
      do_reset();
      ev(1, 12, 32'h0, 32'h12, 0, PC_U);
      chk("R4 mode code", viol_code, 3);
      for (int k = 1; k < d; k++) ev(0, 0, 0, 0, 0, PC_U);
      ev(2, 12, 0, 0, 0, PC_U);
      chk($sformatf("R5 access at %0d", d), mode_cp0_hit, d <= 5);
    end
    do_reset();
    ev(1, 12, 32'h0, 32'h14, 0, PC_U);
    chk("R4 ERL variant", viol_code, 3);
    ev(0, 0, 0, 0, 0, PC_U);
    chk("R5 other class no hit", mode_cp0_hit, 0);

    // R6 safe order
    do_reset();
    ev(1, 12, 32'h0, 32'h2, 0, PC_U);
    chk("R6 EXL first", viol_pulse, 0);
    ev(0, 0, 0, 0, 0, PC_U);
    ev(1, 12, 32'h2, 32'h12, 0, PC_U);
    chk("R6 KSU later", viol_pulse, 0);
    chk("R6 sticky clean", viol_sticky, 0);

    // R7
    do_reset();
    ev(1, 12, 32'h1, 32'h3, 0, PC_U);
    chk("R7 EXL with IE", viol_code, 4);
    do_reset();
    ev(1, 12, 32'h1, 32'h0, 0, PC_U);
    ev(0, 0, 0, 0, 0, PC_U);
    ev(1, 12, 32'h0, 32'h2, 0, PC_U);
    chk("R7 safe order", viol_pulse, 0);

    // R8 window sweep
    for (int d = 1; d <= 4; d++) begin
      do_reset();
      ev(1, 16, 32'h3, 32'h2, 0, PC_K);
      chk("R8 trigger itself", viol_pulse, 0);
      for (int k = 1; k < d; k++) ev(0, 0, 0, 0, 0, PC_U);
      ev(0, 0, 0, 0, 0, PC_K);
      chk($sformatf("R8 kseg0 fetch at %0d", d), viol_code, d <= 3 ? 5 : 0);
    end
    do_reset();
    ev(1, 16, 32'h3, 32'h2, 0, PC_U); ev(0, 0, 0, 0, 0, PC_K);
    chk("R8 trigger outside kseg0", viol_pulse, 0);
    do_reset();
    ev(1, 16, 32'h3, 32'h3, 0, PC_K); ev(0, 0, 0, 0, 0, PC_K);
    chk("R8 K0 unchanged", viol_pulse, 0);

    // R9 priority, R10 sticky
    do_reset();
    ev(1, 12, 32'h1, 32'h13, 0, PC_U);
    chk("R9 lowest code", viol_code, 3);
    chk("R10 two sticky bits", viol_sticky, 5'b01100);
    sticky_clr = 5'b00100; idle();
    chk("R10 clear one bit", viol_sticky, 5'b01000);
    ev(1, 9, 0, 0, 0, PC_U);
    sticky_clr = 5'b00001; ev(2, 9, 0, 0, 0, PC_U);
    chk("R10 set wins over clear", viol_sticky, 5'b01001);
    sticky_clr = 5'b01001; idle();
    chk("R10 clear all", viol_sticky, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule